// File: doc/BRIEF.md
# Serial GPIO Shift-Chain Controller

This block multiplies the number of general-purpose I/O lines a chip offers by running an external daisy chain of shift registers over four pins. These are a serial data output, a serial data input, a shift clock and a load strobe. Software fills a 128-bit output image and reads back a 128-bit input image. The controller moves both images over the chain in one combined pass per frame. It drives each output bit while it samples the matching input bit. When the frame ends, the controller raises the strobe so that the external registers latch their parallel outputs.

The GPIO space is split into 32 ports, each 1 to 4 bits wide. GPIO number `4*p + b` is bit `b` of port `p`. A 32-bit port mask removes whole ports from the stream, so a short chain needs fewer shift clocks. A small write-only register set configures the controller: run mode, bits per port, clock half-period, port mask, a one-shot start and the four output-image words. The shift clock is divided down from the block clock. Frames either repeat back to back or run one at a time on request.

Top module: `sgpio_chain`

## Requirements
- R1: After reset the shift clock, data output, strobe and busy are low and the input image is zero. The port mask resets to all ones, the bits per port to 4, the half-period to 4 clock cycles and run mode to off. A single start then produces 128 shift-clock pulses of 4-cycle high time.
- R2: Each shift-clock level lasts H block-clock cycles. H is the half-period register (address 1, bits [15:0]), and a value of 0 acts as 1. H is captured at frame start.
- R3: Bits travel bit-major. Bit 0 of every enabled port goes first, lowest port first, then bit 1 of every enabled port, and so on. The slot for port p, bit b carries output-image bit 4p+b and fills input-image bit 4p+b.
- R4: A port whose mask bit (address 2, bit p) is 0 gets no slot. With a zero mask a frame has no shift-clock pulses, only the strobe.
- R5: The bits-per-port count is the control register (address 0) field [3:2] plus one.
- R6: The data output changes only while the shift clock is low: at a falling edge or at frame start. The data input is sampled on the cycle the shift clock rises.
- R7: After the last falling edge of a frame the strobe is high for 2H cycles, with the shift clock held low.
- R8: The input image (output port) changes only on the cycle the strobe falls. It then takes every bit sampled in that frame, and bits of unsampled slots keep their values.
- R9: Output-image words (addresses 4 to 7, word k holds GPIO 32k to 32k+31) and all configuration are copied at frame start. Writes during a frame affect only later frames.
- R10: With run (control bit 0) set, the next frame starts on the cycle the strobe ends. Writing 1 to bit 0 of address 3 runs exactly one frame when run is clear. Busy is high exactly while a frame, including its strobe, is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, reference for the shift clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| inImage | output | 128 | Input image committed at the end of the last frame |
| busy | output | 1 | Frame in progress |
| sioClk | output | 1 | Shift clock to the external chain |
| sioOut | output | 1 | Serial data to the chain |
| sioIn | input | 1 | Serial data from the chain |
| sioStrobe | output | 1 | Load strobe to the chain |

## Verification
The bench targets sparse masks, where a design that walks the ports wrongly would send GPIO bits in the wrong slots or shift clocks for disabled ports. It also targets a zero mask, where a naive sequencer either hangs or pulses the clock. A half-period of zero is covered; a design that misreads it would stall or stretch the clock. Output-image writes land in the middle of a frame, and a design without a frame copy would leak them into the running stream. Back-to-back frames make the commit and the restart share one cycle, which exposes a design that loses the sampled bits or inserts an idle gap.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  localparam int RegAddrW = 3;
  localparam logic [RegAddrW-1:0] RegCtrl    = 3'd0;
  localparam logic [RegAddrW-1:0] RegDiv     = 3'd1;
  localparam logic [RegAddrW-1:0] RegMask    = 3'd2;
  localparam logic [RegAddrW-1:0] RegStart   = 3'd3;
  localparam logic [RegAddrW-1:0] RegOutBase = 3'd4;

  typedef enum logic [1:0] {SeqIdle, SeqShift, SeqStrobe} seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // copy output image into the frame copy
    logic drive;   // update serial output from idx
    logic sample;  // capture serial input into slot idx
    logic commit;  // publish the captured frame
  } dpCmd_t;
endpackage

// File: rtl/sgpio_ctrl.sv
module sgpio_ctrl
  import sgpio_pkg::*;
#(
  parameter int NumPorts    = 32,
  parameter int MaxBits     = 4,
  parameter int DivWidth    = 16,
  parameter int DefaultHalf = 4,
  parameter int DataW       = 32,
  localparam int PortW = $clog2(NumPorts),
  localparam int BitW  = (MaxBits > 1) ? $clog2(MaxBits) : 1,
  localparam int IdxW  = $clog2(NumPorts * MaxBits)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [RegAddrW-1:0] wrAddr,
  input  logic [DataW-1:0]    wrData,
  output dpCmd_t              cmd,
  output logic [IdxW-1:0]     idx,
  output logic                sioClk,
  output logic                sioStrobe,
  output logic                busy
);

  logic [NumPorts-1:0] maskReg, maskSnap;
  logic [BitW-1:0]     bppReg, bppSnap, bitIdx, nextBit;
  logic [DivWidth-1:0] divReg, halfSnap, cnt;
  logic [PortW-1:0]    port, nextPort;
  logic [PortW:0]      firstLive, firstSnap, afterCur;
  logic run, pend, phase, sclkQ, strobeQ, tick, frameStart, more;
  seqState_t state;

  // lowest enabled port at or above 'from'; MSB flags a hit
  function automatic logic [PortW:0] findFrom(input logic [NumPorts-1:0] m, input int from);
    logic [PortW:0] r;
    r = '0;
    for (int i = NumPorts - 1; i >= 0; i--)
      if (m[i] && i >= from) r = {1'b1, PortW'(i)};
    return r;
  endfunction

  function automatic logic [IdxW-1:0] slotIdx(input logic [PortW-1:0] p, input logic [BitW-1:0] b);
    return IdxW'(p) * IdxW'(MaxBits) + IdxW'(b);
  endfunction

  assign firstLive = findFrom(maskReg, 0);
  assign firstSnap = findFrom(maskSnap, 0);
  assign afterCur  = findFrom(maskSnap, int'(port) + 1);

  always_comb begin
    more     = 1'b1;
    nextPort = port;
    nextBit  = bitIdx;
    if (afterCur[PortW]) begin
      nextPort = afterCur[PortW-1:0];
    end else if (bitIdx < bppSnap) begin
      nextPort = firstSnap[PortW-1:0];
      nextBit  = bitIdx + 1'b1;
    end else begin
      more = 1'b0;
    end
  end

  assign tick = (state != SeqIdle) && (cnt == halfSnap - DivWidth'(1));

  always_comb begin
    frameStart = 1'b0;
    cmd        = '0;
    idx        = slotIdx(port, bitIdx);
    case (state)
      SeqIdle:  frameStart = run | pend;
      SeqShift: if (tick) begin
        if (!sclkQ) begin
          cmd.sample = 1'b1;
        end else if (more) begin
          cmd.drive = 1'b1;
          idx       = slotIdx(nextPort, nextBit);
        end
      end
      SeqStrobe: if (tick && phase) begin
        cmd.commit = 1'b1;
        frameStart = run | pend;
      end
      default: ;
    endcase
    if (frameStart) begin
      cmd.load  = 1'b1;
      cmd.drive = firstLive[PortW];
      idx       = slotIdx(firstLive[PortW-1:0], '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run      <= 1'b0;
      pend     <= 1'b0;
      bppReg   <= BitW'(MaxBits - 1);
      divReg   <= DivWidth'(DefaultHalf);
      maskReg  <= '1;
      maskSnap <= '1;
      bppSnap  <= '0;
      halfSnap <= DivWidth'(1);
      cnt      <= '0;
      sclkQ    <= 1'b0;
      strobeQ  <= 1'b0;
      phase    <= 1'b0;
      port     <= '0;
      bitIdx   <= '0;
      state    <= SeqIdle;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          RegCtrl: begin
            run    <= wrData[0];
            bppReg <= wrData[2 +: BitW];
          end
          RegDiv:  divReg  <= wrData[DivWidth-1:0];
          RegMask: maskReg <= wrData[NumPorts-1:0];
          default: ;
        endcase
      end
      pend <= (pend & ~frameStart) | (wrEn && wrAddr == RegStart && wrData[0]);

      if (frameStart) cnt <= '0;
      else if (state != SeqIdle) cnt <= tick ? '0 : cnt + 1'b1;

      if (frameStart) begin
        maskSnap <= maskReg;
        bppSnap  <= bppReg;
        halfSnap <= (divReg == '0) ? DivWidth'(1) : divReg;
        sclkQ    <= 1'b0;
        bitIdx   <= '0;
        phase    <= 1'b0;
        if (firstLive[PortW]) begin
          state   <= SeqShift;
          port    <= firstLive[PortW-1:0];
          strobeQ <= 1'b0;
        end else begin
          state   <= SeqStrobe;
          strobeQ <= 1'b1;
        end
      end else if (tick) begin
        case (state)
          SeqShift: begin
            if (!sclkQ) begin
              sclkQ <= 1'b1;
            end else begin
              sclkQ <= 1'b0;
              if (more) begin
                port   <= nextPort;
                bitIdx <= nextBit;
              end else begin
                state   <= SeqStrobe;
                strobeQ <= 1'b1;
                phase   <= 1'b0;
              end
            end
          end
          SeqStrobe: begin
            if (!phase) begin
              phase <= 1'b1;
            end else begin
              strobeQ <= 1'b0;
              state   <= SeqIdle;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sioClk    = sclkQ;
  assign sioStrobe = strobeQ;
  assign busy      = (state != SeqIdle);

endmodule

// File: rtl/sgpio_datapath.sv
module sgpio_datapath
  import sgpio_pkg::*;
#(
  parameter int NumGpio = 128,
  parameter int DataW   = 32,
  localparam int IdxW     = $clog2(NumGpio),
  localparam int NumWords = NumGpio / DataW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [RegAddrW-1:0] wrAddr,
  input  logic [DataW-1:0]    wrData,
  input  dpCmd_t              cmd,
  input  logic [IdxW-1:0]     idx,
  input  logic                sioIn,
  output logic                sioOut,
  output logic [NumGpio-1:0]  inImage
);

  logic [NumGpio-1:0] outImage, frameOut, frameIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outImage <= '0;
      frameOut <= '0;
      frameIn  <= '0;
      inImage  <= '0;
      sioOut   <= 1'b0;
    end else begin
      for (int w = 0; w < NumWords; w++)
        if (wrEn && wrAddr == RegOutBase + RegAddrW'(w))
          outImage[w*DataW +: DataW] <= wrData;
      if (cmd.load)   frameOut <= outImage;
      if (cmd.drive)  sioOut   <= cmd.load ? outImage[idx] : frameOut[idx];
      if (cmd.sample) frameIn[idx] <= sioIn;
      if (cmd.commit) inImage  <= frameIn;
    end
  end

endmodule

// File: rtl/sgpio_chain.sv
module sgpio_chain
  import sgpio_pkg::*;
#(
  parameter int NumPorts    = 32,
  parameter int MaxBits     = 4,
  parameter int DivWidth    = 16,
  parameter int DefaultHalf = 4,
  localparam int DataW   = 32,
  localparam int NumGpio = NumPorts * MaxBits,
  localparam int IdxW    = $clog2(NumGpio)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [31:0]         wrData,
  output logic [NumGpio-1:0]  inImage,
  output logic                busy,
  output logic                sioClk,
  output logic                sioOut,
  input  logic                sioIn,
  output logic                sioStrobe
);

  dpCmd_t          cmd;
  logic [IdxW-1:0] idx;

  sgpio_ctrl #(
    .NumPorts(NumPorts), .MaxBits(MaxBits), .DivWidth(DivWidth),
    .DefaultHalf(DefaultHalf), .DataW(DataW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmd(cmd), .idx(idx), .sioClk(sioClk), .sioStrobe(sioStrobe), .busy(busy)
  );

  sgpio_datapath #(.NumGpio(NumGpio), .DataW(DataW)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmd(cmd), .idx(idx), .sioIn(sioIn), .sioOut(sioOut), .inImage(inImage)
  );

endmodule

// File: rtl/sgpio_chain_chk.sv
module sgpio_chain_chk #(
  parameter int NumGpio = 128
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               sioClk,
  input logic               sioOut,
  input logic               sioStrobe,
  input logic [NumGpio-1:0] inImage
);

  assert_strobe_clk_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    sioStrobe |-> !sioClk);

  assert_out_steady_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    sioClk |-> $stable(sioOut));

  assert_in_commit_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inImage) |-> $fell(sioStrobe));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sioClk && !sioStrobe));

  assert_clk_only_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sioClk) |-> busy);

endmodule

bind sgpio_chain sgpio_chain_chk #(.NumGpio(NumGpio)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sioClk(sioClk), .sioOut(sioOut),
  .sioStrobe(sioStrobe), .inImage(inImage)
);

// File: tb/sim_sgpio_chain.sv
module sim_sgpio_chain;
  localparam int ClkPeriod = 10;
  localparam int MIdle = 0, MShift = 1, MStrobe = 2;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic         sioInDir = 1'b0, randBit = 1'b0, randIn = 1'b0;
  logic         sioIn;
  logic [127:0] inImage;
  logic         busy, sioClk, sioOut, sioStrobe;

  assign sioIn = randIn ? randBit : sioInDir;

  sgpio_chain u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .inImage(inImage), .busy(busy), .sioClk(sioClk), .sioOut(sioOut),
    .sioIn(sioIn), .sioStrobe(sioStrobe)
  );

  always #(ClkPeriod/2) clk = ~clk;
  always @(negedge clk) randBit <= 1'($urandom_range(0, 1));

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mMode, mCnt, mHalf, mPos, mBpp;
  bit mSclk, mSdo, mStrobe, mPhase, mRun, mPend;
  logic [127:0] mOut, mFrameOut, mFrameIn, mIn;
  logic [31:0]  mMask, mDiv;
  int slots[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = MIdle; mCnt = 0; mHalf = 1; mPos = 0; mBpp = 4;
      mSclk = 0; mSdo = 0; mStrobe = 0; mPhase = 0; mRun = 0; mPend = 0;
      mOut = '0; mFrameOut = '0; mFrameIn = '0; mIn = '0;
      mMask = '1; mDiv = 4;
      slots.delete();
    end else begin
      bit tick, go;
      int oldMode;
      oldMode = mMode;
      go = 0;
      tick = (mMode != MIdle) && (mCnt == mHalf - 1);
      case (mMode)
        MIdle: go = mRun || mPend;
        MShift: if (tick) begin
          if (!mSclk) begin
            mSclk = 1;
            mFrameIn[slots[mPos]] = sioIn;
          end else begin
            mSclk = 0;
            mPos++;
            if (mPos < slots.size()) mSdo = mFrameOut[slots[mPos]];
            else begin mMode = MStrobe; mStrobe = 1; mPhase = 0; end
          end
        end
        default: if (tick) begin
          if (!mPhase) mPhase = 1;
          else begin
            mStrobe = 0;
            mIn = mFrameIn;
            mMode = MIdle;
            go = mRun || mPend;
          end
        end
      endcase
      if (oldMode != MIdle) mCnt = tick ? 0 : mCnt + 1;
      if (go) begin
        mFrameOut = mOut;
        slots.delete();
        for (int b = 0; b < mBpp; b++)
          for (int p = 0; p < 32; p++)
            if (mMask[p]) slots.push_back(p * 4 + b);
        mHalf = (mDiv == 0) ? 1 : int'(mDiv);
        mCnt = 0; mSclk = 0; mPos = 0; mPhase = 0;
        if (slots.size() > 0) begin
          mMode = MShift; mStrobe = 0; mSdo = mFrameOut[slots[0]];
        end else begin
          mMode = MStrobe; mStrobe = 1;
        end
      end
      mPend = (mPend && !go) || (wrEn && wrAddr == 3'd3 && wrData[0]);
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mRun = wrData[0]; mBpp = int'(wrData[3:2]) + 1; end
          3'd1: mDiv = {16'd0, wrData[15:0]};
          3'd2: mMask = wrData;
          3'd4, 3'd5, 3'd6, 3'd7: mOut[(int'(wrAddr) - 4) * 32 +: 32] = wrData;
          default: ;
        endcase
      end
    end
  end

  // ---------------- monitor and per-cycle comparison ----------------
  int rises, curHigh, maxHigh, strobeCnt, strobeFalls;
  bit prevClk, prevStrobe;
  logic [3:0] seenVec;

  task automatic clrMon();
    rises = 0; curHigh = 0; maxHigh = 0; strobeCnt = 0; strobeFalls = 0; seenVec = '0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 R3 R6 R7 R10 cycle compare", {124'd0, busy, sioClk, sioOut, sioStrobe},
          {124'd0, mMode != MIdle, mSclk, mSdo, mStrobe});
      chk("R8 cycle compare", inImage, mIn);
      if (sioClk && !prevClk) begin
        rises++;
        seenVec = {seenVec[2:0], sioOut};
      end
      if (sioClk) curHigh++;
      else begin
        if (curHigh > maxHigh) maxHigh = curHigh;
        curHigh = 0;
      end
      if (sioStrobe) strobeCnt++;
      if (prevStrobe && !sioStrobe) strobeFalls++;
    end
    prevClk = sioClk;
    prevStrobe = sioStrobe;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitBusy();
    for (int n = 0; n < 200 && !busy; n++) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    clrMon();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset outputs", {124'd0, busy, sioClk, sioOut, sioStrobe}, 128'd0);
    chk("R1 reset input image", inImage, 128'd0);

    // R1 defaults: full mask, 4 bits per port, half-period 4; input all ones
    sioInDir = 1'b1;
    clrMon();
    wr(3'd3, 32'd1);
    waitBusy(); waitIdle();
    chk("R1 default frame length", 128'(rises), 128'd128);
    chk("R1 default half-period", 128'(maxHigh), 128'd4);
    chk("R8 all slots captured", inImage, {128{1'b1}});

    // sparse mask: ports 0 and 2, 2 bits per port, H=2
    wr(3'd1, 32'd2);
    wr(3'd2, 32'h0000_0005);
    wr(3'd0, 32'h0000_0004);
    wr(3'd4, 32'h0000_0203);
    sioInDir = 1'b0;
    clrMon();
    wr(3'd3, 32'd1);
    waitBusy();
    wr(3'd4, 32'h0000_0100);      // mid-frame write
    waitIdle();
    // slots in order: gpio0, gpio8, gpio1, gpio9
    chk("R3 R9 bit-major order, old image", 128'(seenVec), 128'(4'b1011));
    chk("R5 two bits per port", 128'(rises), 128'd4);
    chk("R2 half-period 2", 128'(maxHigh), 128'd2);
    chk("R7 strobe width 2H", 128'(strobeCnt), 128'd4);
    chk("R8 unsampled bits kept", inImage, ~128'h303);
    clrMon();
    wr(3'd3, 32'd1);
    waitBusy(); waitIdle();
    chk("R9 new image next frame", 128'(seenVec), 128'(4'b0100));
    clrMon();
    repeat (30) @(negedge clk);
    chk("R10 single frame only", {127'd0, busy}, 128'd0);
    chk("R10 no clocks after one-shot", 128'(rises), 128'd0);

    // zero mask: strobe only
    wr(3'd1, 32'd3);
    wr(3'd2, 32'd0);
    clrMon();
    wr(3'd3, 32'd1);
    waitBusy(); waitIdle();
    chk("R4 no clocks with empty mask", 128'(rises), 128'd0);
    chk("R4 strobe still issued", 128'(strobeCnt), 128'd6);

    // continuous run, divider 0 acts as 1, ports 0 and 31, one bit each
    wr(3'd1, 32'd0);
    wr(3'd2, 32'h8000_0001);
    randIn = 1'b1;
    clrMon();
    wr(3'd0, 32'h0000_0001);
    repeat (200) @(negedge clk);
    chk("R10 back-to-back frames", {127'd0, strobeFalls >= 10}, 128'd1);
    chk("R2 divider zero acts as one", 128'(maxHigh), 128'd1);
    wr(3'd0, 32'd0);
    waitIdle();
    chk("R10 stops when run cleared", {127'd0, busy}, 128'd0);

    // full chain, H=1, continuous with random mid-frame image writes
    wr(3'd1, 32'd1);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0000_000D);
    for (int k = 0; k < 16; k++) begin
      wr(3'(4 + k % 4), $urandom);
      repeat (35) @(negedge clk);
    end
    wr(3'd0, 32'h0000_000C);
    waitIdle();
    randIn = 1'b0;
    chk("R10 idle after continuous run", {127'd0, busy}, 128'd0);
    summary();
  end

endmodule